// File: doc/BRIEF.md
# Configurable asynchronous serial transceiver

This block is a full-duplex asynchronous serial port. The transmitter and the receiver work independently of each other, and both are paced by one shared tick. The tick comes from a programmable divider, and a bit lasts sixteen ticks. A four-bit format input picks the character layout. The data field is seven or eight bits long. Parity can be absent, even or odd. The character ends with one or two stop bits. Together these give twelve distinct layouts.

Each direction holds one character in a buffer next to its shift register. Software can write the next byte while the current one is still leaving on the line, and successive characters then go out with no idle time between them. On the receive side, a finished character waits in the buffer with its error flags until it is read. The format is captured at the start of each character, so the format can change between characters.

The line rests high. A character begins with a low start bit, the data follows least significant bit first, and the stop bits are high. The receiver aligns to the falling edge of the start bit and samples each bit on the eighth tick of that bit.

Top module: `sio_port`

## Requirements
- R1: After reset, txd is high, tx_end is 1, and tx_full, rx_full, err_frame, err_parity and err_overrun are all 0.
- R2: A transmitted character has this layout: a low start bit; then the data least significant bit first (eight bits when fmt[0]=1, seven when fmt[0]=0); then a parity bit when fmt[1]=1; then high stop bits, two when fmt[3]=1 and one otherwise. The parity is even when fmt[2]=0 and odd when fmt[2]=1, meaning the total number of ones in the data and parity bits is even or odd respectively.
- R3: A write with wr_en while tx_full=0 sets tx_full on the next cycle. A write while tx_full=1 is ignored. A byte already buffered begins its start bit exactly when the previous character's last stop bit ends.
- R4: tx_end is 1 exactly when the buffer and the shift register are both empty. While tx_end is 1, txd stays high.
- R5: The receiver decodes all twelve layouts and shows the data on rd_data, least significant bit first, with bit 7 zero in seven-bit mode. It sets rx_full when the character completes. rd_en while rx_full=1 clears rx_full and all three error flags.
- R6: A low pulse on rxd that is high again by the eighth tick after the start was detected delivers no character.
- R7: err_frame is set together with rx_full when the first stop bit samples low.
- R8: err_parity is set together with rx_full when parity is enabled and the received parity bit does not match the data for the selected sense.
- R9: When a character completes while rx_full=1, err_overrun is set and the unread rd_data is kept unchanged. A read clears err_overrun.
- R10: The tick period is baud_div+1 clock cycles, so one bit lasts 16*(baud_div+1) cycles in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_div | input | DIV_W | Tick divider; the tick period is baud_div+1 cycles |
| fmt | input | 4 | Layout: [0] eight data bits, [1] parity on, [2] odd parity, [3] two stop bits |
| wr_en | input | 1 | Write strobe for the transmit buffer |
| wr_data | input | 8 | Byte to transmit |
| tx_full | output | 1 | Transmit buffer holds a byte |
| tx_end | output | 1 | Transmitter fully idle |
| txd | output | 1 | Serial transmit line |
| rd_en | input | 1 | Read strobe for the receive buffer |
| rd_data | output | 8 | Last received byte |
| rx_full | output | 1 | Receive buffer holds an unread byte |
| err_frame | output | 1 | Stop bit of the buffered character sampled low |
| err_parity | output | 1 | Parity mismatch on the buffered character |
| err_overrun | output | 1 | A character was lost because the buffer was unread |
| rxd | input | 1 | Serial receive line |

## Verification
The properties assume that baud_div and fmt only change while neither direction has a character in flight. They also assume that every bit on rxd lasts a whole number of bit periods, apart from the deliberate glitch and the shortened bad stop bit. The stimulus follows these assumptions. It changes the divider and the format only after tx_end has risen and the receiver has been idle for at least half a bit. It drives rxd from the bench's own bit timer, which is derived from the divider value the bench selected. It holds reads back whenever it is provoking an overrun.

// File: rtl/sio_port.sv
module sio_port #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] baud_div,
  input  logic [3:0]       fmt,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  output logic             tx_full,
  output logic             tx_end,
  output logic             txd,
  input  logic             rd_en,
  output logic [7:0]       rd_data,
  output logic             rx_full,
  output logic             err_frame,
  output logic             err_parity,
  output logic             err_overrun,
  input  logic             rxd
);
  localparam int FRAME_W = 12;
  localparam int SUB_W   = 4;
  localparam logic [SUB_W-1:0] MID_TICK = SUB_W'(7);
  localparam logic [SUB_W-1:0] END_TICK = SUB_W'(15);

  logic [DIV_W-1:0] div_cnt;
  logic             tick;

  assign tick = (div_cnt >= baud_div);

  always_ff @(posedge clk) begin
    if (!rst_n)    div_cnt <= '0;
    else if (tick) div_cnt <= '0;
    else           div_cnt <= div_cnt + 1'b1;
  end

  logic [7:0]         tx_buf;
  logic [FRAME_W-1:0] tx_sh, tx_frame;
  logic [3:0]         tx_left, tx_len;
  logic [SUB_W-1:0]   tx_sub;
  logic               tx_busy, tx_par, tx_last, tx_load;

  always_comb begin
    tx_frame    = '1;
    tx_frame[0] = 1'b0;
    for (int i = 0; i < 8; i++)
      if (i < 7 || fmt[0]) tx_frame[1+i] = tx_buf[i];
    tx_par = ^(tx_buf & {fmt[0], 7'h7f}) ^ fmt[2];
    if (fmt[1]) begin
      if (fmt[0]) tx_frame[9] = tx_par;
      else        tx_frame[8] = tx_par;
    end
    tx_len = 4'd9 + {3'b0, fmt[0]} + {3'b0, fmt[1]} + {3'b0, fmt[3]};
  end

  assign tx_last = tx_busy && tx_sub == END_TICK && tx_left == 4'd1;
  assign tx_load = tick && tx_full && (!tx_busy || tx_last);
  assign txd     = tx_busy ? tx_sh[0] : 1'b1;
  assign tx_end  = !tx_busy && !tx_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_buf  <= '0;
      tx_full <= 1'b0;
      tx_busy <= 1'b0;
      tx_sh   <= '1;
      tx_sub  <= '0;
      tx_left <= '0;
    end else begin
      if (wr_en && !tx_full) begin
        tx_buf  <= wr_data;
        tx_full <= 1'b1;
      end
      if (tick && tx_busy) begin
        tx_sub <= tx_sub + 1'b1;
        if (tx_sub == END_TICK) begin
          tx_sh   <= {1'b1, tx_sh[FRAME_W-1:1]};
          tx_left <= tx_left - 1'b1;
          if (tx_left == 4'd1) tx_busy <= 1'b0;
        end
      end
      if (tx_load) begin
        tx_sh   <= tx_frame;
        tx_left <= tx_len;
        tx_sub  <= '0;
        tx_busy <= 1'b1;
        tx_full <= 1'b0;
      end
    end
  end

  logic [1:0]       rx_sync;
  logic             rx_in, rx_busy, rx_par;
  logic [SUB_W-1:0] rx_sub;
  logic [3:0]       rx_idx, rx_dl, rx_stop, rx_fmt;
  logic [2:0]       rx_bit;
  logic [7:0]       rx_sh;

  assign rx_in   = rx_sync[1];
  assign rx_dl   = rx_fmt[0] ? 4'd8 : 4'd7;
  assign rx_stop = rx_dl + 4'd1 + {3'b0, rx_fmt[1]};
  assign rx_bit  = 3'(rx_idx - 4'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) rx_sync <= 2'b11;
    else        rx_sync <= {rx_sync[0], rxd};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_busy     <= 1'b0;
      rx_sub      <= '0;
      rx_idx      <= '0;
      rx_fmt      <= '0;
      rx_sh       <= '0;
      rx_par      <= 1'b0;
      rd_data     <= '0;
      rx_full     <= 1'b0;
      err_frame   <= 1'b0;
      err_parity  <= 1'b0;
      err_overrun <= 1'b0;
    end else begin
      if (rd_en && rx_full) begin
        rx_full     <= 1'b0;
        err_frame   <= 1'b0;
        err_parity  <= 1'b0;
        err_overrun <= 1'b0;
      end
      if (tick) begin
        if (!rx_busy) begin
          if (!rx_in) begin
            rx_busy <= 1'b1;
            rx_sub  <= '0;
            rx_idx  <= '0;
            rx_fmt  <= fmt;
            rx_sh   <= '0;
          end
        end else begin
          rx_sub <= rx_sub + 1'b1;
          if (rx_sub == MID_TICK) begin
            rx_idx <= rx_idx + 1'b1;
            if (rx_idx == 4'd0) begin
              if (rx_in) rx_busy <= 1'b0;
            end else if (rx_idx <= rx_dl) begin
              rx_sh[rx_bit] <= rx_in;
            end else if (rx_idx == rx_stop) begin
              rx_busy <= 1'b0;
              if (rx_full && !rd_en) begin
                err_overrun <= 1'b1;
              end else begin
                rd_data    <= rx_sh;
                rx_full    <= 1'b1;
                err_frame  <= !rx_in;
                err_parity <= rx_fmt[1] & (^rx_sh ^ rx_par ^ rx_fmt[2]);
              end
            end else begin
              rx_par <= rx_in;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/sio_port_chk.sv
module sio_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       tx_full,
  input logic       tx_end,
  input logic       txd,
  input logic       rd_en,
  input logic       rx_full,
  input logic [7:0] rd_data,
  input logic       err_overrun
);
  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n) tx_end |-> txd); // R4
  AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rst_n) wr_en && !tx_full |=> tx_full); // R3
  AST_FILL_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n) $rose(tx_full) |-> $past(wr_en)); // R3
  AST_UNREAD_HELD: assert property (@(posedge clk) disable iff (!rst_n) rx_full && !rd_en |=> rx_full && $stable(rd_data)); // R9
  AST_READ_CLEARS_OVR: assert property (@(posedge clk) disable iff (!rst_n) rd_en |=> !err_overrun); // R9
  AST_OVR_WHILE_FULL: assert property (@(posedge clk) disable iff (!rst_n) err_overrun |-> rx_full); // R9
endmodule

bind sio_port sio_port_chk i_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .tx_full(tx_full), .tx_end(tx_end),
  .txd(txd), .rd_en(rd_en), .rx_full(rx_full), .rd_data(rd_data),
  .err_overrun(err_overrun)
);

// File: tb/test_sio_port.sv
module test_sio_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] baud_div = 16'd3;
  logic [3:0]  fmt = 4'b0001;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = 8'h00;
  logic        rd_en = 1'b0;
  logic        rxl = 1'b1;
  logic        loop = 1'b0;
  logic        tx_full, tx_end, txd, rx_full, err_frame, err_parity, err_overrun, rxd;
  logic [7:0]  rd_data;
  int          checks = 0, errors = 0, div_v = 3;
  logic [11:0] exp_q[$];
  bit          done = 1'b0;

  always #2 clk = ~clk;
  assign rxd = loop ? txd : rxl;

  sio_port #(.DIV_W(16)) i_sio_port (
    .clk(clk), .rst_n(rst_n), .baud_div(baud_div), .fmt(fmt),
    .wr_en(wr_en), .wr_data(wr_data), .tx_full(tx_full), .tx_end(tx_end), .txd(txd),
    .rd_en(rd_en), .rd_data(rd_data), .rx_full(rx_full), .err_frame(err_frame),
    .err_parity(err_parity), .err_overrun(err_overrun), .rxd(rxd)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int mkframe(input logic [7:0] b, input logic [3:0] f, output logic [11:0] v);
    int n = 0, ones = 0, dl;
    dl = f[0] ? 8 : 7;
    v = '1;
    v[n] = 1'b0; n++;
    for (int i = 0; i < dl; i++) begin
      v[n] = b[i];
      ones += int'(b[i]);
      n++;
    end
    if (f[1]) begin
      v[n] = ((ones % 2) == 1) ^ f[2];
      n++;
    end
    n += f[3] ? 2 : 1;
    return n;
  endfunction

  task automatic tx_frame(output bit cont);
    logic [11:0] e, v;
    int n, bc, bad;
    bad = -1;
    cont = 1'b0;
    if (exp_q.size() == 0) begin
      chk(1'b0, "R3 unexpected frame on txd", 1, 0);
      while (txd !== 1'b1) @(negedge clk);
      return;
    end
    e = exp_q.pop_front();
    n = mkframe(e[7:0], e[11:8], v);
    bc = 16 * (div_v + 1);
    for (int k = 0; k < n * bc; k++) begin
      if (k > 0) @(negedge clk);
      if (txd !== v[k / bc] && bad < 0) bad = k;
    end
    chk(bad < 0, "R2 R10 transmitted frame, first bad cycle", bad, -1);
    if (exp_q.size() > 0) begin
      @(negedge clk);
      chk(txd === 1'b0, "R3 buffered byte starts without gap", int'(txd), 0);
      cont = (txd === 1'b0);
    end
  endtask

  initial begin : monitor
    bit cont;
    forever begin
      @(negedge clk);
      if (txd === 1'b0) begin
        cont = 1'b1;
        while (cont) tx_frame(cont);
      end
    end
  end

  task automatic wr(input logic [7:0] b, input bit accept);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = b;
    if (accept) exp_q.push_back({fmt, b});
    @(negedge clk);
    wr_en = 1'b0;
    chk(tx_full === 1'b1, "R3 tx_full after write", int'(tx_full), 1);
  endtask

  task automatic rd(input string req);
    @(negedge clk);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    chk(rx_full === 1'b0 && err_overrun === 1'b0 && err_frame === 1'b0 && err_parity === 1'b0,
        req, {rx_full, err_overrun, err_frame, err_parity}, 0);
  endtask

  task automatic wait_end();
    @(negedge clk);
    while (tx_end !== 1'b1) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b, input logic [3:0] f, input bit bad_par, input bit bad_stop);
    logic [11:0] v;
    int n, bc, sidx;
    fmt = f;
    n = mkframe(b, f, v);
    bc = 16 * (div_v + 1);
    sidx = 1 + (f[0] ? 8 : 7) + int'(f[1]);
    if (bad_par) v[sidx-1] = ~v[sidx-1];
    for (int k = 0; k < n; k++) begin
      if (bad_stop && k == sidx) begin
        rxl = 1'b0;
        repeat (bc * 5 / 8) @(negedge clk);
        rxl = 1'b1;
        repeat (bc - bc * 5 / 8) @(negedge clk);
      end else begin
        rxl = v[k];
        repeat (bc) @(negedge clk);
      end
    end
    rxl = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog run not finished actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] b;
    logic [3:0] fv;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(txd === 1'b1, "R1 txd idle high", int'(txd), 1);
    chk(tx_end === 1'b1, "R1 tx_end", int'(tx_end), 1);
    chk(tx_full === 1'b0, "R1 tx_full", int'(tx_full), 0);
    chk(rx_full === 1'b0, "R1 rx_full", int'(rx_full), 0);
    chk({err_frame, err_parity, err_overrun} === 3'b000, "R1 error flags", {err_frame, err_parity, err_overrun}, 0);

    loop = 1'b1;
    for (int f = 0; f < 16; f++) begin
      fv = 4'(f);
      if (fv[2] && !fv[1]) continue;
      fmt = fv;
      b = 8'hC3 ^ 8'(f * 23);
      wr(b, 1'b1);
      chk(tx_end === 1'b0, "R4 tx_end low while busy", int'(tx_end), 0);
      wait_end();
      chk(txd === 1'b1, "R4 txd high at tx_end", int'(txd), 1);
      chk(rx_full === 1'b1, "R5 loopback character received", int'(rx_full), 1);
      chk(rd_data === (fv[0] ? b : (b & 8'h7f)), "R5 loopback data", rd_data, fv[0] ? b : (b & 8'h7f));
      chk({err_frame, err_parity, err_overrun} === 3'b000, "R5 R7 R8 no error on clean frame",
          {err_frame, err_parity, err_overrun}, 0);
      rd("R5 read clears rx_full");
    end

    baud_div = 16'd7;
    div_v = 7;
    fmt = 4'b0001;
    wr(8'h96, 1'b1);
    wait_end();
    chk(rx_full === 1'b1 && rd_data === 8'h96, "R10 slower divider loopback", rd_data, 8'h96);
    rd("R10 read after slow frame");
    baud_div = 16'd3;
    div_v = 3;
    loop = 1'b0;
    repeat (8) @(negedge clk);

    fmt = 4'b1011;
    wr(8'h5A, 1'b1);
    while (tx_full === 1'b1) @(negedge clk);
    wr(8'hE1, 1'b1);
    wr(8'h0F, 1'b0);
    chk(tx_end === 1'b0, "R4 tx_end low with byte pending", int'(tx_end), 0);
    wait_end();
    repeat (1000) @(negedge clk);
    chk(exp_q.size() == 0 && tx_end === 1'b1, "R3 ignored write never sent", exp_q.size(), 0);

    rxl = 1'b0;
    repeat (16) @(negedge clk);
    rxl = 1'b1;
    repeat (192) @(negedge clk);
    chk(rx_full === 1'b0, "R6 short start pulse rejected", int'(rx_full), 0);

    send(8'h3C, 4'b0001, 1'b0, 1'b1);
    repeat (64) @(negedge clk);
    chk(rx_full === 1'b1 && rd_data === 8'h3C, "R7 data with framing error", rd_data, 8'h3C);
    chk(err_frame === 1'b1 && err_parity === 1'b0, "R7 err_frame set", {err_frame, err_parity}, 2);
    rd("R7 read clears err_frame");

    send(8'h55, 4'b0110, 1'b1, 1'b0);
    chk(rx_full === 1'b1 && rd_data === 8'h55, "R8 data with parity error", rd_data, 8'h55);
    chk(err_parity === 1'b1 && err_frame === 1'b0, "R8 err_parity set", {err_parity, err_frame}, 2);
    rd("R8 read clears err_parity");

    send(8'hB4, 4'b0100, 1'b0, 1'b0);
    chk(rx_full === 1'b1 && rd_data === 8'h34 && err_parity === 1'b0, "R5 seven-bit odd setting without parity",
        rd_data, 8'h34);
    rd("R5 read seven-bit");

    send(8'h11, 4'b1001, 1'b0, 1'b0);
    send(8'h22, 4'b1001, 1'b0, 1'b0);
    chk(err_overrun === 1'b1, "R9 overrun flagged", int'(err_overrun), 1);
    chk(rx_full === 1'b1 && rd_data === 8'h11, "R9 unread data kept", rd_data, 8'h11);
    rd("R9 read clears overrun");

    repeat (20) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule